// File: doc/BRIEF.md
# Fully Associative Coalescing First-Level TLB

This block is a small first-level translation buffer in which every entry can hold either a 4 KiB base page or a 16 KiB coalesced page. There are no index bits, so every entry is compared against the lookup page number, and translations of both sizes share one pool of storage. The lookup answers in the same cycle it is presented: hit flag, physical frame number and permission bits. A coalesced entry supplies the upper frame bits, and the lowest two frame bits come from the lookup page number.

On a miss the block stops accepting lookups. In the next cycle it sends a single request carrying the missed page number to a second-level translation port. It then waits for the fill response, which arrives about six cycles later. The fill is installed into a free entry if one exists, otherwise into the entry chosen by a tree pseudo-LRU. If the three other base pages of the same aligned four-page group are already resident, map to consecutive frames and have the same permissions, and the new frame is aligned the same way, the four are merged into one coalesced entry and the old base entries are freed. Invalidate-by-page and flush inputs remove translations.

Top module: `tlb_l1`

## Requirements
- R1: When `lk_valid` and `lk_ready` are both high and a valid entry covers `lk_vpn`, `lk_hit` is high in that same cycle. `lk_ppn` and `lk_perm` then give that translation: the stored frame for a base entry, or the stored upper frame bits joined to `lk_vpn[1:0]` for a coalesced entry. Without `lk_valid && lk_ready`, `lk_hit` is low.
- R2: A lookup accepted with no covering entry makes `l2_req_valid` high for exactly one cycle, the next one, with `l2_req_vpn` equal to the missed page. `lk_ready` is low from that cycle until the cycle after `l2_rsp_valid` is seen.
- R3: After a fill response, a lookup of the missed page hits and returns the frame and permission bits of the response.
- R4: A fill merges into one coalesced entry when all of these hold: the response frame satisfies `ppn[1:0] == vpn[1:0]`; the other three pages of the group (`vpn` with bits [1:0] replaced by 0..3) are resident as base entries; each of them has frame `{ppn[PPN_W-1:2], vpn[1:0]}` and permissions equal to the response. All four pages then hit with their own frames, and invalidating any one of them removes all four.
- R5: A group whose frames are not aligned that way, or whose permissions differ, stays as separate base entries. Invalidating one page leaves the others hitting.
- R6: A cycle with `inv_valid` high removes every entry that covers `inv_vpn`, whether base or coalesced. From the next cycle on, lookups of the removed pages miss.
- R7: A cycle with `flush` high removes all entries, so every later lookup misses until a new fill. A fill in the same cycle as a flush or invalidate is still installed.
- R8: A fill takes the lowest-numbered free entry. With all 32 entries valid it takes the tree pseudo-LRU victim. After 32 fills into an empty buffer and no hits, the 33rd fill evicts the first page filled and keeps the other 32.
- R9: No two valid entries ever cover the same page, so every hit returns one unique translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_ready | output | 1 | Lookup accepted (low while a miss is outstanding) |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_ppn | output | 20 | Physical frame number of the hit |
| lk_perm | output | 4 | Permission bits of the hit |
| l2_req_valid | output | 1 | One-cycle request to the second level |
| l2_req_vpn | output | 20 | Page number being requested |
| l2_rsp_valid | input | 1 | Fill response from the second level |
| l2_rsp_ppn | input | 20 | Frame number of the fill |
| l2_rsp_perm | input | 4 | Permission bits of the fill |
| inv_valid | input | 1 | Invalidate the entry covering inv_vpn |
| inv_vpn | input | 20 | Page number to invalidate |
| flush | input | 1 | Remove all entries |

## Verification
The assertions assume three things about the inputs. `l2_rsp_valid` is raised only while a miss is outstanding and only after the request has gone out. A fill response is a single-cycle pulse. Each page always maps to the same frame and permissions. The bench keeps to this by answering each request exactly once, six cycles after it, from a fixed mapping function. It also issues lookups only while `lk_ready` is high, and it applies invalidates and flushes only between lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VPN_W  = 20;
  parameter int PPN_W  = 20;
  parameter int PERM_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } miss_state_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [N-1:0]            big,
  input  logic [N-1:0]            vld,
  input  logic [VPN_W-1:0]        probe,
  output logic [N-1:0]            match
);
  localparam logic [VPN_W-1:0] BIG_MASK = {{(VPN_W-2){1'b1}}, 2'b00};

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [VPN_W-1:0] mask;
    assign mask     = big[i] ? BIG_MASK : {VPN_W{1'b1}};
    assign match[i] = vld[i] && (((tags[i] ^ probe) & mask) == '0);
  end
endmodule

// File: rtl/tlb_group.sv
module tlb_group
  import tlb_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0][VPN_W-1:0]  tags,
  input  logic [N-1:0][PPN_W-1:0]  ppns,
  input  logic [N-1:0][PERM_W-1:0] perms,
  input  logic [N-1:0]             big,
  input  logic [N-1:0]             vld,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic [PERM_W-1:0]        fill_perm,
  output logic [N-1:0]             in_group,
  output logic                     can_merge
);
  logic [N-1:0][3:0] peer;
  logic [3:0]        have;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign in_group[i] = vld[i] && (tags[i][VPN_W-1:2] == fill_vpn[VPN_W-1:2]);
    for (genvar j = 0; j < 4; j++) begin : g_off
      assign peer[i][j] = in_group[i] && !big[i] && (tags[i][1:0] == j[1:0])
                          && (ppns[i] == {fill_ppn[PPN_W-1:2], j[1:0]})
                          && (perms[i] == fill_perm);
    end
  end

  always_comb begin
    have = '0;
    for (int i = 0; i < N; i++) have = have | peer[i];
    can_merge = (fill_ppn[1:0] == fill_vpn[1:0]);
    for (int j = 0; j < 4; j++) begin
      if (j[1:0] != fill_vpn[1:0] && !have[j]) can_merge = 1'b0;
    end
  end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int N = 32,
  localparam int LVL = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           touch,
  input  logic [LVL-1:0] touch_idx,
  output logic [LVL-1:0] victim
);
  logic [N-2:0] tree_q, tree_d;
  logic [LVL:0] walk_v, walk_t;

  always_comb begin
    walk_v = 1;
    for (int l = 0; l < LVL; l++) walk_v = {walk_v[LVL-1:0], tree_q[walk_v - 1]};
    victim = walk_v[LVL-1:0];
  end

  always_comb begin
    tree_d = tree_q;
    walk_t = 1;
    if (touch) begin
      for (int l = 0; l < LVL; l++) begin
        tree_d[walk_t - 1] = ~touch_idx[LVL-1-l];
        walk_t = {walk_t[LVL-1:0], touch_idx[LVL-1-l]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tree_q <= '0;
    else if (touch) tree_q <= tree_d;
  end
endmodule

// File: rtl/tlb_l1.sv
module tlb_l1
  import tlb_pkg::*;
#(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_ready,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  output logic              l2_req_valid,
  output logic [VPN_W-1:0]  l2_req_vpn,
  input  logic              l2_rsp_valid,
  input  logic [PPN_W-1:0]  l2_rsp_ppn,
  input  logic [PERM_W-1:0] l2_rsp_perm,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              flush
);
  logic [N-1:0][VPN_W-1:0]  tag_q;
  logic [N-1:0][PPN_W-1:0]  ppn_q;
  logic [N-1:0][PERM_W-1:0] perm_q;
  logic [N-1:0]             big_q, vld_q, vld_d, vld_live;
  logic [N-1:0]             lk_match, inv_match, fill_match, grp_match, fill_clr, avail;
  miss_state_t              st_q, st_d;
  logic [VPN_W-1:0]         miss_q;
  logic                     miss_en, rsp_fire, can_merge, any_free, touch;
  logic [IDX_W-1:0]         hit_idx, free_idx, plru_vic, victim, touch_idx;

  tlb_cam #(.N(N)) u_cam_lk  (.tags(tag_q), .big(big_q), .vld(vld_q),
                              .probe(lk_vpn), .match(lk_match));
  tlb_cam #(.N(N)) u_cam_inv (.tags(tag_q), .big(big_q), .vld(vld_q),
                              .probe(inv_vpn), .match(inv_match));
  tlb_cam #(.N(N)) u_cam_fil (.tags(tag_q), .big(big_q), .vld(vld_live),
                              .probe(miss_q), .match(fill_match));
  tlb_group #(.N(N)) u_group (.tags(tag_q), .ppns(ppn_q), .perms(perm_q), .big(big_q),
                              .vld(vld_live), .fill_vpn(miss_q), .fill_ppn(l2_rsp_ppn),
                              .fill_perm(l2_rsp_perm), .in_group(grp_match),
                              .can_merge(can_merge));
  tlb_plru #(.N(N)) u_plru (.clk(clk), .rst_n(rst_n), .touch(touch),
                            .touch_idx(touch_idx), .victim(plru_vic));

  // lookup side
  assign lk_ready = (st_q == ST_IDLE);
  assign lk_hit   = lk_valid && lk_ready && (|lk_match);

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) if (lk_match[i]) hit_idx = i[IDX_W-1:0];
    lk_ppn  = big_q[hit_idx] ? {ppn_q[hit_idx][PPN_W-1:2], lk_vpn[1:0]} : ppn_q[hit_idx];
    lk_perm = perm_q[hit_idx];
  end

  // miss sequencing
  assign miss_en      = (st_q == ST_IDLE) && lk_valid && !(|lk_match);
  assign rsp_fire     = (st_q == ST_WAIT) && l2_rsp_valid;
  assign l2_req_valid = (st_q == ST_REQ);
  assign l2_req_vpn   = miss_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (miss_en) st_d = ST_REQ;
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (l2_rsp_valid) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // removal, then fill placement
  assign vld_live = flush ? '0 : (vld_q & ~(inv_valid ? inv_match : '0));
  assign fill_clr = can_merge ? grp_match : fill_match;
  assign avail    = vld_live & ~(rsp_fire ? fill_clr : '0);

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!avail[i]) begin
        free_idx = i[IDX_W-1:0];
        any_free = 1'b1;
      end
    end
    victim = any_free ? free_idx : plru_vic;
    vld_d  = avail;
    if (rsp_fire) vld_d[victim] = 1'b1;
  end

  assign touch     = lk_hit || rsp_fire;
  assign touch_idx = rsp_fire ? victim : hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      vld_q <= '0;
    end else begin
      st_q  <= st_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_en) miss_q <= lk_vpn;
    if (rsp_fire) begin
      big_q[victim]  <= can_merge;
      tag_q[victim]  <= can_merge ? {miss_q[VPN_W-1:2], 2'b00} : miss_q;
      ppn_q[victim]  <= can_merge ? {l2_rsp_ppn[PPN_W-1:2], 2'b00} : l2_rsp_ppn;
      perm_q[victim] <= l2_rsp_perm;
    end
  end
endmodule

// File: rtl/tlb_l1_chk.sv
module tlb_l1_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lk_valid,
  input logic         lk_ready,
  input logic         lk_hit,
  input logic         l2_req_valid,
  input logic         l2_rsp_valid,
  input logic         flush,
  input logic         rsp_fire,
  input logic [N-1:0] lk_match,
  input logic [N-1:0] vld_q
);
  a_r1_hit_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_valid && lk_ready));

  a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_valid |=> !l2_req_valid);

  a_r2_busy_during_req: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_valid |-> !lk_ready);

  a_r2_miss_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !lk_hit) |=> l2_req_valid);

  a_r3_fill_frees_port: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_ready && l2_rsp_valid && !l2_req_valid) |=> lk_ready);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !rsp_fire) |=> (vld_q == '0));

  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

bind tlb_l1 tlb_l1_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_hit(lk_hit), .l2_req_valid(l2_req_valid), .l2_rsp_valid(l2_rsp_valid),
  .flush(flush), .rsp_fire(rsp_fire), .lk_match(lk_match), .vld_q(vld_q)
);

// File: tb/tlb_l1_tb.sv
module tlb_l1_tb;
  logic        clk, rst_n;
  logic        lk_valid, lk_ready, lk_hit;
  logic [19:0] lk_vpn, lk_ppn;
  logic [3:0]  lk_perm;
  logic        l2_req_valid, l2_rsp_valid;
  logic [19:0] l2_req_vpn, l2_rsp_ppn;
  logic [3:0]  l2_rsp_perm;
  logic        inv_valid, flush;
  logic [19:0] inv_vpn;
  int          n_run, n_fail;
  bit          done;

  tlb_l1 u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [19:0] ppn_of(input logic [19:0] v);
    logic [1:0] lo;
    lo = (v[19:16] == 4'hF) ? ~v[1:0] : v[1:0];
    return {v[19:2] ^ 18'h2A5C3, lo};
  endfunction

  function automatic logic [3:0] perm_of(input logic [19:0] v);
    return (v[19:16] == 4'hE) ? {3'b010, v[0]} : 4'b0101;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one lookup; a miss is served by the second-level model
  task automatic look(input logic [19:0] v, output logic hit);
    @(posedge clk); #1;
    lk_valid = 1'b1; lk_vpn = v;
    @(negedge clk);
    hit = lk_hit;
    if (hit) begin
      chk("R1 ppn", lk_ppn, ppn_of(v));
      chk("R1 perm", lk_perm, perm_of(v));
    end
    @(posedge clk); #1;
    lk_valid = 1'b0;
    if (!hit) begin
      @(negedge clk);
      chk("R2 req valid", l2_req_valid, 1'b1);
      chk("R2 req vpn", l2_req_vpn, v);
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R2 ready low", lk_ready, 1'b0);
      chk("R2 req single", l2_req_valid, 1'b0);
      @(posedge clk); #1;
      l2_rsp_valid = 1'b1; l2_rsp_ppn = ppn_of(v); l2_rsp_perm = perm_of(v);
      @(posedge clk); #1;
      l2_rsp_valid = 1'b0;
      @(negedge clk);
      chk("R2 ready back", lk_ready, 1'b1);
    end
  endtask

  task automatic expect_look(input string req, input logic [19:0] v, input logic exp_hit);
    logic h;
    look(v, h);
    chk(req, h, exp_hit);
  endtask

  task automatic do_inv(input logic [19:0] v);
    @(posedge clk); #1; inv_valid = 1'b1; inv_vpn = v;
    @(posedge clk); #1; inv_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1; flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic h;
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; lk_valid = 1'b0; lk_vpn = '0; l2_rsp_valid = 1'b0;
    l2_rsp_ppn = '0; l2_rsp_perm = '0; inv_valid = 1'b0; inv_vpn = '0; flush = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("reset ready", lk_ready, 1'b1);
    chk("reset req", l2_req_valid, 1'b0);
    chk("reset hit", lk_hit, 1'b0);

    // R3 basic fill then hit
    expect_look("R3 first miss", 20'h0A001, 1'b0);
    expect_look("R3 hit after fill", 20'h0A001, 1'b1);

    // R4 and R9 coalescing of an aligned contiguous group
    for (int j = 0; j < 4; j++) expect_look("R4 group fill miss", 20'h12340 + j, 1'b0);
    for (int j = 0; j < 4; j++) expect_look("R9 group hit", 20'h12340 + j, 1'b1);
    do_inv(20'h12342);
    expect_look("R4 coalesced removed", 20'h12341, 1'b0);
    expect_look("R4 coalesced removed", 20'h12343, 1'b0);

    // R5 misaligned frames: no merge
    for (int j = 0; j < 4; j++) expect_look("R5 fill", 20'hF0000 + j, 1'b0);
    do_inv(20'hF0001);
    expect_look("R5 neighbour kept", 20'hF0000, 1'b1);
    expect_look("R5 neighbour kept", 20'hF0003, 1'b1);
    expect_look("R6 base removed", 20'hF0001, 1'b0);
    // R5 differing permissions: no merge
    for (int j = 0; j < 4; j++) expect_look("R5 fill perm", 20'hE0010 + j, 1'b0);
    do_inv(20'hE0012);
    expect_look("R5 perm neighbour kept", 20'hE0011, 1'b1);
    expect_look("R6 perm page removed", 20'hE0012, 1'b0);

    // R7 flush
    do_flush();
    expect_look("R7 flushed", 20'h0A001, 1'b0);
    expect_look("R7 flushed", 20'hF0000, 1'b0);

    // R8 capacity and replacement
    do_flush();
    for (int k = 0; k < 33; k++) expect_look("R8 fill", 20'h30000 + 4 * k, 1'b0);
    for (int k = 1; k < 33; k++) expect_look("R8 kept", 20'h30000 + 4 * k, 1'b1);
    expect_look("R8 oldest evicted", 20'h30000, 1'b0);

    // random mix on a small page pool
    void'($urandom(32'h1F2E3D4C));
    for (int it = 0; it < 400; it++) begin
      logic [19:0] v;
      int r;
      r = $urandom_range(0, 63);
      v = 20'h50000 + 20'($urandom_range(0, 47));
      if (r < 4) do_inv(v);
      else if (r == 5) do_flush();
      else begin
        look(v, h);
        if (!h) expect_look("R3 random refill hit", v, 1'b1);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule